// File: doc/BRIEF.md
# Outstanding-Operation Wait Counter

This unit keeps a live count of three kinds of operations that a shader core has issued but not yet seen finish. The three kinds are vector memory accesses, export writes, and a combined class of data-share and scalar-memory accesses. Each class has an issue pulse and a completion pulse. The unit exposes the three counts as outputs.

When the sequencer reaches a wait instruction, it raises a one-cycle request strobe together with the instruction's 16-bit immediate. That immediate packs one threshold per class, and the thresholds have different widths. The unit holds the stall output high until every enabled class count has fallen to or below its threshold. A field filled with all ones switches off waiting on its class. If the thresholds are already satisfied when the request arrives, the stall output never goes high.

The counters saturate at their maximum instead of wrapping. A completion that arrives when its count is already zero is dropped, and the unit raises an error flag for one cycle.

Top module: `wait_count_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, all three counts read zero and both stall and cpl_err are low.
- R2: An issue pulse without a completion pulse on the same class raises that count by one at the next clock edge. A completion pulse without an issue pulse lowers it by one at the next clock edge.
- R3: When the issue and completion pulses of a class are both high in the same cycle, that class's count is unchanged at the next edge.
- R4: The counts saturate: vector memory at 15, export at 7, and data-share/scalar at 31. An issue pulse at the maximum leaves the count at the maximum.
- R5: A completion pulse (with no issue pulse) on a class whose count is zero leaves the count at zero. It sets cpl_err high for exactly the following cycle.
- R6: The threshold fields in wait_imm are bits 3:0 for vector memory, bits 6:4 for export, and bits 12:8 for data-share/scalar. Bits 7 and 15:13 have no effect.
- R7: A field value of 4'hF, 3'h7 or 5'h1F, respectively, removes that class from the wait condition, whatever its count.
- R8: In the cycle wait_req is high, stall is high if any enabled class count is greater than its threshold.
- R9: Once high, stall stays high while any enabled count exceeds the captured threshold. It drops in the first cycle all conditions hold. It never rises without a new wait_req.
- R10: A wait_req that arrives when every condition already holds produces no stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vmem_iss | input | 1 | Vector memory operation issued |
| vmem_cpl | input | 1 | Vector memory operation completed |
| xpt_iss | input | 1 | Export write issued |
| xpt_cpl | input | 1 | Export write completed |
| smem_iss | input | 1 | Data-share or scalar-memory operation issued |
| smem_cpl | input | 1 | Data-share or scalar-memory operation completed |
| wait_req | input | 1 | One-cycle wait request strobe |
| wait_imm | input | 16 | Packed thresholds that come with wait_req |
| stall | output | 1 | High while the wait conditions are unmet |
| vmem_cnt | output | 4 | Outstanding vector memory operations |
| xpt_cnt | output | 3 | Outstanding export writes |
| smem_cnt | output | 5 | Outstanding data-share/scalar operations |
| cpl_err | output | 1 | One-cycle flag for a completion seen at zero count |

## Verification
The bench drives every counter past its ceiling and below zero. A counter that wraps would read zero after saturation, and a counter that does not ignore an underflow would read all ones, and both show up as count mismatches. Wait requests are aimed at each field in turn, with the unused immediate bits set. A field decoded at the wrong offset, or an all-ones value not treated as a disable, would then stall when it should not, or release too early. The release cycle is checked exactly while completions drain the count one per cycle. A request whose conditions are already met is also issued, and a registered-only stall path would show a spurious or a missing first stall cycle.

// File: rtl/wait_count_unit.sv
module wait_count_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vmem_iss,
  input  logic        vmem_cpl,
  input  logic        xpt_iss,
  input  logic        xpt_cpl,
  input  logic        smem_iss,
  input  logic        smem_cpl,
  input  logic        wait_req,
  input  logic [15:0] wait_imm,
  output logic        stall,
  output logic [3:0]  vmem_cnt,
  output logic [2:0]  xpt_cnt,
  output logic [4:0]  smem_cnt,
  output logic        cpl_err
);

  logic        pend;
  logic [15:0] thr_q;

  wire [15:0] thr = wait_req ? wait_imm : thr_q;
  wire [3:0]  v_lim = thr[3:0];
  wire [2:0]  x_lim = thr[6:4];
  wire [4:0]  s_lim = thr[12:8];

  wire v_ok = (v_lim == 4'hF)  || (vmem_cnt <= v_lim);
  wire x_ok = (x_lim == 3'h7)  || (xpt_cnt  <= x_lim);
  wire s_ok = (s_lim == 5'h1F) || (smem_cnt <= s_lim);

  assign stall = (wait_req | pend) & ~(v_ok & x_ok & s_ok);

  wire v_up  = vmem_iss & ~vmem_cpl & (vmem_cnt != 4'hF);
  wire v_dn  = vmem_cpl & ~vmem_iss & (vmem_cnt != 4'h0);
  wire v_bad = vmem_cpl & ~vmem_iss & (vmem_cnt == 4'h0);
  wire x_up  = xpt_iss & ~xpt_cpl & (xpt_cnt != 3'h7);
  wire x_dn  = xpt_cpl & ~xpt_iss & (xpt_cnt != 3'h0);
  wire x_bad = xpt_cpl & ~xpt_iss & (xpt_cnt == 3'h0);
  wire s_up  = smem_iss & ~smem_cpl & (smem_cnt != 5'h1F);
  wire s_dn  = smem_cpl & ~smem_iss & (smem_cnt != 5'h00);
  wire s_bad = smem_cpl & ~smem_iss & (smem_cnt == 5'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmem_cnt <= '0;
      xpt_cnt  <= '0;
      smem_cnt <= '0;
      cpl_err  <= 1'b0;
      pend     <= 1'b0;
      thr_q    <= '0;
    end else begin
      if (v_up) vmem_cnt <= vmem_cnt + 4'd1;
      else if (v_dn) vmem_cnt <= vmem_cnt - 4'd1;
      if (x_up) xpt_cnt <= xpt_cnt + 3'd1;
      else if (x_dn) xpt_cnt <= xpt_cnt - 3'd1;
      if (s_up) smem_cnt <= smem_cnt + 5'd1;
      else if (s_dn) smem_cnt <= smem_cnt - 5'd1;
      cpl_err <= v_bad | x_bad | s_bad;
      pend    <= stall;
      if (wait_req) thr_q <= wait_imm;
    end
  end

  p_inc_vmem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vmem_iss && !vmem_cpl && vmem_cnt != 4'hF) |=> vmem_cnt == $past(vmem_cnt) + 4'd1);

  p_dec_smem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smem_cpl && !smem_iss && smem_cnt != 5'h00) |=> smem_cnt == $past(smem_cnt) - 5'd1);

  p_both_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xpt_iss && xpt_cpl) |=> $stable(xpt_cnt));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vmem_cnt == 4'hF && vmem_iss && !vmem_cpl) |=> vmem_cnt == 4'hF);

  p_underflow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xpt_cpl && !xpt_iss && xpt_cnt == 3'h0) |=> (cpl_err && xpt_cnt == 3'h0));

  p_disabled_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && wait_imm[3:0] == 4'hF && wait_imm[6:4] == 3'h7 && wait_imm[12:8] == 5'h1F) |-> !stall);

  p_no_spurious_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (!stall || wait_req));

endmodule

// File: tb/test_wait_count_unit.sv
module test_wait_count_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vmem_iss = 0, vmem_cpl = 0, xpt_iss = 0, xpt_cpl = 0, smem_iss = 0, smem_cpl = 0;
  logic        wait_req = 0;
  logic [15:0] wait_imm = '0;
  logic        stall, cpl_err;
  logic [3:0]  vmem_cnt;
  logic [2:0]  xpt_cnt;
  logic [4:0]  smem_cnt;

  always #2 clk = ~clk;

  wait_count_unit i_wait_count_unit (
    .clk(clk), .rst_n(rst_n),
    .vmem_iss(vmem_iss), .vmem_cpl(vmem_cpl),
    .xpt_iss(xpt_iss), .xpt_cpl(xpt_cpl),
    .smem_iss(smem_iss), .smem_cpl(smem_cpl),
    .wait_req(wait_req), .wait_imm(wait_imm),
    .stall(stall), .vmem_cnt(vmem_cnt), .xpt_cnt(xpt_cnt),
    .smem_cnt(smem_cnt), .cpl_err(cpl_err)
  );

  typedef struct {
    logic [3:0] v;
    logic [2:0] x;
    logic [4:0] s;
    logic       err;
    logic       stl;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  localparam logic [5:0] VI = 6'b000001, VC = 6'b000010, XI = 6'b000100,
                         XC = 6'b001000, SI = 6'b010000, SC = 6'b100000;

  logic [3:0]  m_v = 0;
  logic [2:0]  m_x = 0;
  logic [4:0]  m_s = 0;
  logic        m_err = 0, m_pend = 0;
  logic [15:0] m_thr = 0;

  function automatic logic met(input logic [15:0] t);
    logic a, b, c;
    a = (t[3:0] == 4'hF) || (m_v <= t[3:0]);
    b = (t[6:4] == 3'h7) || (m_x <= t[6:4]);
    c = (t[12:8] == 5'h1F) || (m_s <= t[12:8]);
    return a && b && c;
  endfunction

  task automatic cyc(input logic [5:0] ev, input logic wr, input logic [15:0] imm, input string tag);
    exp_t e;
    logic st;
    @(negedge clk);
    {smem_cpl, smem_iss, xpt_cpl, xpt_iss, vmem_cpl, vmem_iss} = ev;
    wait_req = wr;
    wait_imm = imm;
    st = (wr || m_pend) && !met(wr ? imm : m_thr);
    e.v = m_v; e.x = m_x; e.s = m_s; e.err = m_err; e.stl = st; e.tag = tag;
    exp_q.push_back(e);
    m_err = (ev[1] && !ev[0] && m_v == 0) || (ev[3] && !ev[2] && m_x == 0) ||
            (ev[5] && !ev[4] && m_s == 0);
    if (ev[0] && !ev[1] && m_v != 4'hF) m_v = m_v + 1;
    else if (ev[1] && !ev[0] && m_v != 0) m_v = m_v - 1;
    if (ev[2] && !ev[3] && m_x != 3'h7) m_x = m_x + 1;
    else if (ev[3] && !ev[2] && m_x != 0) m_x = m_x - 1;
    if (ev[4] && !ev[5] && m_s != 5'h1F) m_s = m_s + 1;
    else if (ev[5] && !ev[4] && m_s != 0) m_s = m_s - 1;
    m_pend = st;
    if (wr) m_thr = imm;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (vmem_cnt !== e.v || xpt_cnt !== e.x || smem_cnt !== e.s ||
            cpl_err !== e.err || stall !== e.stl) begin
          n_bad++;
          $display("FAIL %s: got v=%0d x=%0d s=%0d err=%0b stall=%0b, expected v=%0d x=%0d s=%0d err=%0b stall=%0b",
                   e.tag, vmem_cnt, xpt_cnt, smem_cnt, cpl_err, stall,
                   e.v, e.x, e.s, e.err, e.stl);
        end
      end
    end
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;
    if (vmem_cnt !== 0 || xpt_cnt !== 0 || smem_cnt !== 0 || stall !== 0 || cpl_err !== 0) begin
      n_bad++;
      $display("FAIL R1 in reset: got v=%0d x=%0d s=%0d stall=%0b err=%0b, expected all zero",
               vmem_cnt, xpt_cnt, smem_cnt, stall, cpl_err);
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1 after reset");

    cyc(VI, 0, 0, "R2 vmem issue");
    cyc(VI | XI | SI, 0, 0, "R2 all issue");
    cyc(VI | SI, 0, 0, "R2 issue");
    cyc(SI | XI, 0, 0, "R2 issue");
    cyc(VC, 0, 0, "R2 vmem complete");
    cyc(SC | XC, 0, 0, "R2 complete");
    cyc(0, 0, 0, "R2 settle");

    cyc(VI | VC | XI | XC | SI | SC, 0, 0, "R3 simultaneous");
    cyc(VI | VC | SC, 0, 0, "R3 vmem simultaneous");
    cyc(0, 0, 0, "R3 settle");

    for (int i = 0; i < 34; i++) cyc(VI | XI | SI, 0, 0, "R4 fill");
    cyc(0, 0, 0, "R4 saturated");
    for (int i = 0; i < 31; i++) cyc(VC | XC | SC, 0, 0, "R2 drain");
    cyc(VC, 0, 0, "R5 vmem at zero");
    cyc(0, 0, 0, "R5 flag one cycle");
    cyc(XC, 0, 0, "R5 export at zero");
    cyc(SC | VI, 0, 0, "R5 smem at zero");
    cyc(0, 0, 0, "R5 settle");
    cyc(VC, 0, 0, "R5 drain");

    for (int i = 0; i < 3; i++) cyc(VI, 0, 0, "R8 setup");
    cyc(0, 1, 16'h1F71, "R8 vmem wait");
    cyc(VC, 0, 0, "R9 held");
    cyc(VC, 0, 0, "R9 release");
    cyc(0, 0, 0, "R9 no restall");
    cyc(0, 1, 16'h1F71, "R10 already met");
    cyc(0, 0, 0, "R10 idle");

    cyc(XI, 0, 0, "R6 setup");
    cyc(XI, 0, 0, "R6 setup");
    cyc(0, 1, 16'hFF9F, "R6 export field with stray bits");
    cyc(0, 0, 0, "R6 held");
    cyc(XC, 0, 0, "R6 export drain");
    cyc(0, 0, 0, "R6 released");
    cyc(XC, 0, 0, "R6 drain");

    for (int i = 0; i < 5; i++) cyc(SI, 0, 0, "R6 smem setup");
    cyc(0, 1, 16'h037F, "R6 smem field");
    cyc(SC, 0, 0, "R9 smem held");
    cyc(SC, 0, 0, "R9 smem release");
    cyc(0, 0, 0, "R9 idle");

    for (int i = 0; i < 4; i++) cyc(VI | XI, 0, 0, "R7 setup");
    cyc(0, 1, 16'h1F7F, "R7 all disabled");
    cyc(0, 1, 16'h1F0F, "R7 export enabled");
    cyc(XC, 0, 0, "R7 held");
    cyc(XC, 0, 0, "R7 held");
    cyc(XC, 0, 0, "R7 held");
    cyc(XC, 0, 0, "R7 released");
    cyc(0, 1, 16'h1F70, "R8 vmem zero threshold");
    cyc(0, 0, 0, "R9 vmem held");

    repeat (3) @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule